// File: doc/BRIEF.md
# Auto-Increment Display RAM Access Controller

This block sits between a byte-stream command front end and a display RAM that holds 4 banks of 40 bytes each. A data pointer has two parts, a bank index and a column (X) address. Load strobes set it, and it steps forward by one after every data byte that is accepted. The RAM is addressed as bank×40 + X, and X equals the column number. Columns 0 to 7 are never shown on the display, but they store and return data like any other column.

A 4-bit subaddress counter steps forward together with the pointer. A written byte reaches the RAM only while this counter equals the device's fixed subaddress of 0. This lets several devices share one write stream, with each device taking every sixteenth byte. Reads are not gated by the counter. Each accepted read returns the byte at the pointer one cycle later.

The master ends a read stream by flagging its last byte as not acknowledged. After that, further read requests are ignored and the data output idles high until a load strobe opens a new transfer.

Top module: `disp_ram_seq`

## Requirements
- R1: After reset, the bank, X address and subaddress counter are 0, so `ram_addr_o` is 0 and the first written byte is stored. `rdata_vld_o` is 0 and `rdata_o` is 8'hFF.
- R2: `ram_addr_o` equals bank×40 + X. `ld_bank_i` loads the bank from `bank_i`. `ld_x_i` loads X from `x_i`, and a loaded value of 40 or more becomes 0.
- R3: Each accepted data byte advances X by one. When X is at 39 it goes to 0 instead, and the bank advances modulo 4 (bank 3 goes to bank 0).
- R4: Each accepted data byte advances the subaddress counter by one, and 15 goes to 0. `ld_sub_i` loads the counter from `sub_i`.
- R5: A write byte (`byte_vld_i`=1, `rd_i`=0) raises `ram_we_o` in the same cycle and stores `wdata_i` at `ram_addr_o`. This happens only when the counter is 0. Otherwise the RAM is left unchanged, although the pointer and the counter still advance.
- R6: An accepted read byte (`rd_i`=1) makes `rdata_o` show the stored byte at that address in the next cycle, with `rdata_vld_o`=1. Columns 0 to 7 read back like any other column.
- R7: A read byte with `nack_i`=1 is still returned, but it closes the read stream. Later read requests are then ignored: no data is returned and neither the pointer nor the counter moves. Any load strobe reopens the stream.
- R8: If any load strobe is active in the same cycle as a data byte, the load takes effect and the byte is dropped: no write and no advance.
- R9: In every cycle that does not follow an accepted read, `rdata_vld_o` is 0 and `rdata_o` is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_bank_i | input | 1 | Load the bank index |
| bank_i | input | 2 | Bank value to load |
| ld_x_i | input | 1 | Load the X address |
| x_i | input | 6 | X value to load |
| ld_sub_i | input | 1 | Load the subaddress counter |
| sub_i | input | 4 | Counter value to load |
| byte_vld_i | input | 1 | A data byte is transferred this cycle |
| rd_i | input | 1 | 1 = read byte, 0 = write byte |
| nack_i | input | 1 | Read byte is the last one, not acknowledged |
| wdata_i | input | 8 | Write data |
| ram_addr_o | output | 8 | Current RAM address, bank×40 + X |
| ram_we_o | output | 1 | RAM write enable |
| rdata_o | output | 8 | Registered read data, 8'hFF when idle |
| rdata_vld_o | output | 1 | Read data is valid |

## Verification
The RAM region is first filled with bytes written one at a time, with the counter reloaded to 0 before each byte. A sequential read of columns 0 to 11 then shows that the address path and the hidden columns behave correctly.

A 20-byte write stream that starts with the counter at 14 should store only two bytes, where the counter passes 0. This separates correct gating and correct 15-to-0 wrap from an off-by-one in either.

Single writes at column 39 of bank 1 and of bank 3 check the column and bank carries. A read stream ended by a nack, followed by an extra read request, shows that the stream closes. A load issued together with a data byte confirms that the load takes precedence.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int unsigned N_BANK_D = 4;
  localparam int unsigned N_COL_D  = 40;
  localparam int unsigned DW_D     = 8;
  localparam int unsigned SUB_W_D  = 4;

  typedef enum logic [1:0] {OP_IDLE, OP_WR, OP_RD} op_e;
endpackage

// File: rtl/disp_ptr.sv
module disp_ptr #(
  parameter int unsigned N_BANK = 4,
  parameter int unsigned N_COL  = 40,
  localparam int unsigned BANK_W = $clog2(N_BANK),
  localparam int unsigned X_W    = $clog2(N_COL),
  localparam int unsigned AW     = $clog2(N_BANK * N_COL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_bank_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              ld_x_i,
  input  logic [X_W-1:0]    x_i,
  input  logic              adv_i,
  output logic [AW-1:0]     addr_o
);
  logic [BANK_W-1:0] bank_q;
  logic [X_W-1:0]    x_q;
  logic              x_last, bank_last;

  assign x_last    = (x_q == X_W'(N_COL - 1));
  assign bank_last = (bank_q == BANK_W'(N_BANK - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      x_q    <= '0;
    end else if (ld_bank_i || ld_x_i) begin
      if (ld_bank_i) bank_q <= bank_i;
      if (ld_x_i)    x_q    <= (32'(x_i) < N_COL) ? x_i : '0;
    end else if (adv_i) begin
      if (x_last) begin
        x_q    <= '0;
        bank_q <= bank_last ? '0 : bank_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  assign addr_o = AW'(bank_q) * AW'(N_COL) + AW'(x_q);
endmodule

// File: rtl/disp_sub.sv
module disp_sub #(
  parameter int unsigned SUB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [SUB_W-1:0] val_i,
  input  logic             adv_i,
  output logic [SUB_W-1:0] sub_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sub_o <= '0;
    else if (ld_i)   sub_o <= val_i;
    else if (adv_i)  sub_o <= sub_o + 1'b1;  // natural wrap
  end
endmodule

// File: rtl/disp_mem.sv
module disp_mem #(
  parameter int unsigned DEPTH = 160,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          vld_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  // idle value all-ones: released line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '1;
      vld_o   <= 1'b0;
    end else begin
      rdata_o <= re_i ? mem_q[addr_i] : '1;
      vld_o   <= re_i;
    end
  end
endmodule

// File: rtl/disp_ram_seq.sv
module disp_ram_seq
  import disp_pkg::*;
#(
  parameter int unsigned N_BANK = N_BANK_D,
  parameter int unsigned N_COL  = N_COL_D,
  parameter int unsigned DW     = DW_D,
  parameter int unsigned SUB_W  = SUB_W_D,
  parameter logic [SUB_W-1:0] HW_SUB = '0
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             ld_bank_i,
  input  logic [$clog2(N_BANK)-1:0]        bank_i,
  input  logic                             ld_x_i,
  input  logic [$clog2(N_COL)-1:0]         x_i,
  input  logic                             ld_sub_i,
  input  logic [SUB_W-1:0]                 sub_i,
  input  logic                             byte_vld_i,
  input  logic                             rd_i,
  input  logic                             nack_i,
  input  logic [DW-1:0]                    wdata_i,
  output logic [$clog2(N_BANK*N_COL)-1:0]  ram_addr_o,
  output logic                             ram_we_o,
  output logic [DW-1:0]                    rdata_o,
  output logic                             rdata_vld_o
);
  localparam int unsigned DEPTH = N_BANK * N_COL;

  logic             any_ld, rd_open_q, adv_w, hit_w;
  logic [SUB_W-1:0] sub_w;
  op_e              op;

  assign any_ld = ld_bank_i | ld_x_i | ld_sub_i;

  always_comb begin
    op = OP_IDLE;
    if (byte_vld_i && !any_ld) begin
      if (!rd_i)          op = OP_WR;
      else if (rd_open_q) op = OP_RD;
    end
  end

  assign adv_w    = (op != OP_IDLE);
  assign hit_w    = (sub_w == HW_SUB);
  assign ram_we_o = (op == OP_WR) && hit_w;

  // read stream closes on nacked byte, reopens on any load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rd_open_q <= 1'b1;
    else if (any_ld)                    rd_open_q <= 1'b1;
    else if (op == OP_RD && nack_i)     rd_open_q <= 1'b0;
  end

  disp_ptr #(.N_BANK(N_BANK), .N_COL(N_COL)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_bank_i (ld_bank_i),
    .bank_i    (bank_i),
    .ld_x_i    (ld_x_i),
    .x_i       (x_i),
    .adv_i     (adv_w),
    .addr_o    (ram_addr_o)
  );

  disp_sub #(.SUB_W(SUB_W)) u_sub (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ld_sub_i),
    .val_i  (sub_i),
    .adv_i  (adv_w),
    .sub_o  (sub_w)
  );

  disp_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ram_we_o),
    .re_i    (op == OP_RD),
    .addr_i  (ram_addr_o),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .vld_o   (rdata_vld_o)
  );
endmodule

// File: rtl/disp_ram_seq_chk.sv
module disp_ram_seq_chk #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 8,
  parameter int unsigned SUB_W = 4,
  parameter int unsigned DEPTH = 160
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ld_bank_i,
  input logic             ld_x_i,
  input logic             ld_sub_i,
  input logic             byte_vld_i,
  input logic             rd_i,
  input logic [AW-1:0]    ram_addr_o,
  input logic             ram_we_o,
  input logic [DW-1:0]    rdata_o,
  input logic             rdata_vld_o,
  input logic             rd_open_q,
  input logic             adv_w,
  input logic [SUB_W-1:0] sub_w
);
  logic any_ld;
  assign any_ld = ld_bank_i | ld_x_i | ld_sub_i;

  a_r2_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ram_addr_o) < DEPTH);

  a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_vld_i && !any_ld) |=> $stable(ram_addr_o));

  a_r4_sub_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_w && !ld_sub_i) |=> (sub_w == SUB_W'($past(sub_w) + 1'b1)));

  a_r6_rd_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && rd_i && rd_open_q && !any_ld) |=> rdata_vld_o);

  a_r7_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && rd_i && !rd_open_q && !any_ld) |=> (!rdata_vld_o && $stable(ram_addr_o)));

  a_r8_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_ld |-> !ram_we_o);

  a_r9_idle_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_vld_o |-> (rdata_o == '1));
endmodule

bind disp_ram_seq disp_ram_seq_chk #(
  .AW($clog2(N_BANK*N_COL)), .DW(DW), .SUB_W(SUB_W), .DEPTH(N_BANK*N_COL)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ld_bank_i   (ld_bank_i),
  .ld_x_i      (ld_x_i),
  .ld_sub_i    (ld_sub_i),
  .byte_vld_i  (byte_vld_i),
  .rd_i        (rd_i),
  .ram_addr_o  (ram_addr_o),
  .ram_we_o    (ram_we_o),
  .rdata_o     (rdata_o),
  .rdata_vld_o (rdata_vld_o),
  .rd_open_q   (rd_open_q),
  .adv_w       (adv_w),
  .sub_w       (sub_w)
);

// File: tb/disp_ram_seq_tb.sv
module disp_ram_seq_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ld_bank = 0, ld_x = 0, ld_sub = 0, byte_vld = 0, rd = 0, nack = 0;
  logic [1:0] bank_v = '0;
  logic [5:0] x_v = '0;
  logic [3:0] sub_v = '0;
  logic [7:0] wdata = '0;
  logic [7:0] ram_addr, rdata;
  logic       ram_we, rdata_vld;

  int n_chk = 0, n_fail = 0;
  int mb = 0, mx = 0, ms = 0;
  bit mopen = 1;
  logic [7:0] mm [160];
  logic [7:0] exp_q [$];
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  disp_ram_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ld_bank_i(ld_bank), .bank_i(bank_v),
    .ld_x_i(ld_x), .x_i(x_v), .ld_sub_i(ld_sub), .sub_i(sub_v),
    .byte_vld_i(byte_vld), .rd_i(rd), .nack_i(nack), .wdata_i(wdata),
    .ram_addr_o(ram_addr), .ram_we_o(ram_we), .rdata_o(rdata), .rdata_vld_o(rdata_vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int maddr();
    return mb * 40 + mx;
  endfunction

  function automatic void madv();
    if (mx == 39) begin mx = 0; mb = (mb + 1) % 4; end
    else mx++;
    ms = (ms + 1) % 16;
  endfunction

  task automatic idle();
    ld_bank = 0; ld_x = 0; ld_sub = 0; byte_vld = 0; rd = 0; nack = 0;
  endtask

  task automatic ld_ptr(input int b, input int x);
    ld_bank = 1; bank_v = 2'(b); ld_x = 1; x_v = 6'(x);
    @(negedge clk); idle();
    mb = b; mx = (x < 40) ? x : 0; mopen = 1;
    chk(ram_addr == 8'(maddr()), "R2 load addr", ram_addr, maddr());
  endtask

  task automatic ld_sub_t(input int s);
    ld_sub = 1; sub_v = 4'(s);
    @(negedge clk); idle();
    ms = s; mopen = 1;
  endtask

  task automatic wr(input logic [7:0] d);
    byte_vld = 1; rd = 0; wdata = d;
    #1;
    chk(ram_we == (ms == 0), "R5 write enable", ram_we, ms == 0);
    chk(ram_addr == 8'(maddr()), "R3 write addr", ram_addr, maddr());
    @(negedge clk); idle();
    if (ms == 0) mm[maddr()] = d;
    madv();
  endtask

  task automatic rd_t(input bit last);
    byte_vld = 1; rd = 1; nack = last;
    #1;
    chk(ram_addr == 8'(maddr()), "R6 read addr", ram_addr, maddr());
    chk(ram_we == 0, "R6 no write on read", ram_we, 0);
    if (mopen) begin
      exp_q.push_back(mm[maddr()]);
      madv();
      if (last) mopen = 0;
    end
    @(negedge clk); idle();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rdata_vld) begin
        if (exp_q.size() == 0) chk(0, "R7 unexpected read data", rdata, -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rdata == e, "R6 read data", rdata, e);
        end
      end else begin
        chk(rdata == 8'hFF, "R9 idle data", rdata, 255);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ram_addr == 0, "R1 reset addr", ram_addr, 0);
    chk(rdata_vld == 0, "R1 reset valid", rdata_vld, 0);
    chk(rdata == 8'hFF, "R1 reset data", rdata, 255);
    rst_n = 1;
    @(negedge clk);

    // R1: first write after reset stored (counter 0); fill bank0 x0..11
    for (int i = 0; i < 12; i++) begin
      if (i != 0) ld_sub_t(0);
      wr(8'(8'hA0 + i));
    end

    // R6: read back including hidden columns 0..7, last byte nacked (R7)
    ld_ptr(0, 0);
    for (int i = 0; i < 12; i++) rd_t(i == 11);
    @(negedge clk);
    rd_t(0);  // stream closed: ignored
    @(negedge clk);
    chk(rdata_vld == 0, "R7 closed no data", rdata_vld, 0);
    chk(ram_addr == 8'(maddr()), "R7 pointer held", ram_addr, maddr());

    // R2
    ld_ptr(2, 5);
    chk(ram_addr == 85, "R2 bank2 x5", ram_addr, 85);
    ld_ptr(1, 50);
    chk(ram_addr == 40, "R2 x clamp", ram_addr, 40);

    // R3 column and bank carry
    ld_ptr(1, 39); ld_sub_t(0); wr(8'h5C);
    chk(ram_addr == 80, "R3 x wrap to bank2", ram_addr, 80);
    ld_ptr(3, 39); ld_sub_t(0); wr(8'h3F);
    chk(ram_addr == 0, "R3 bank wrap to 0", ram_addr, 0);

    // R4/R5 gating stream: prefill bank2 x0..19
    ld_ptr(2, 0);
    for (int i = 0; i < 20; i++) begin ld_sub_t(0); wr(8'hEE); end
    ld_ptr(2, 0); ld_sub_t(14);
    for (int i = 0; i < 20; i++) wr(8'(8'h10 + i));
    ld_ptr(2, 0);
    for (int i = 0; i < 20; i++) rd_t(i == 19);
    chk(mm[82] == 8'h12 && mm[98] == 8'h22, "R4 model hits", mm[82], 8'h12);

    // R8 load beats data byte
    ld_ptr(0, 0);
    ld_x = 1; x_v = 6'd7; byte_vld = 1; rd = 0; wdata = 8'h99;
    #1;
    chk(ram_we == 0, "R8 no write with load", ram_we, 0);
    @(negedge clk); idle();
    mx = 7; mopen = 1;
    chk(ram_addr == 7, "R8 load taken", ram_addr, 7);
    rd_t(1);  // expect 0xA7, not 0x99
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule